// File: doc/BRIEF.md
# Dual Oscillator Race Readout Controller

This block is the synchronous readout for a pair of configurable oscillator cells. Each cell can run either as a free-running ring oscillator or as a transient oscillator that settles to a fixed level. The controller drives one shared enable to both cells. It brings each cell's oscillation edges into the system clock domain and counts them in a per-cell counter. It then turns the two counts and the two settled levels into response bits.

In ring mode the evaluation is a race. The first counter to reach all ones wins, the other counter freezes, and bits are taken from the frozen count. In transient mode the enable is held for a fixed window of system-clock cycles. The two counts are then compared and subtracted, the settled levels are captured, and a mixed bit is formed from them. A single start pulse launches an evaluation, and a one-cycle done pulse marks the moment the results become valid.

Top module: `osc_race_readout`

## Requirements
- R1: After reset, osc_en_o, done_o, sign_o, tie_o, mix_o, clps_a_o, clps_b_o, loser_bits_o and diff_o are all zero.
- R2: A start_i sampled high while the block is idle clears both counters, latches mode_i and raises osc_en_o on the next cycle. A start_i sampled during an evaluation has no effect on it or its results.
- R3: Each counter (CNT_W bits) counts the synchronized rising edges of its cell while osc_en_o is high. It saturates at all ones and never wraps.
- R4: In ring mode (mode_i = 0) the evaluation ends in the cycle after a counter reaches all ones, and the other counter freezes at its value in that cycle. sign_o = 1 means cell A filled first. If both counters fill in the same cycle, sign_o = 0 and tie_o = 1.
- R5: loser_bits_o[k] is bit CNT_W-SEL_FIRST-(SEL_N-1-k) of the losing count. Equivalently, bit SEL_N-1 is the bit at position SEL_FIRST counted from the MSB, where the MSB is position 1. The losing count is B's count when sign_o = 1 and A's count otherwise.
- R6: In transient mode (mode_i = 1), osc_en_o stays high for exactly WIN_CYC cycles, whatever the counts are.
- R7: In transient mode, sign_o = 1 exactly when A's count exceeds B's count, and tie_o = 1 exactly when the counts are equal.
- R8: diff_o is A's count minus B's count as a CNT_W+1 bit two's complement value.
- R9: clps_a_o and clps_b_o are the synchronized collapse inputs captured at the end of the evaluation, and mix_o = clps_a_o ^ clps_b_o ^ sign_o.
- R10: done_o is high for exactly one cycle per evaluation, and osc_en_o is low while done_o is high. osc_en_o stays low for at least two cycles between evaluations. The results hold until the next evaluation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches an evaluation when idle |
| mode_i | input | 1 | 0 = ring race, 1 = transient window |
| osc_a_i | input | 1 | Asynchronous oscillation output of cell A |
| osc_b_i | input | 1 | Asynchronous oscillation output of cell B |
| clps_a_i | input | 1 | Settled level of cell A |
| clps_b_i | input | 1 | Settled level of cell B |
| osc_en_o | output | 1 | Common enable to both cells |
| done_o | output | 1 | One-cycle pulse: results valid |
| sign_o | output | 1 | A won the race or oscillated longer |
| tie_o | output | 1 | Counts equal |
| loser_bits_o | output | SEL_N | Selected bits of the losing count |
| diff_o | output | CNT_W+1 | Count A minus count B |
| clps_a_o | output | 1 | Captured settled level of A |
| clps_b_o | output | 1 | Captured settled level of B |
| mix_o | output | 1 | XOR of both settled levels and sign |

## Verification
The assertions assume that each oscillator input stays at one level for at least one full clock cycle and changes slower than half the clock rate. Under that assumption the synchronizer never misses a rising edge, so counts are exact and a filled counter stays full. The bench drives the cells at the falling clock edge with periods of three or more cycles, and only while osc_en_o is high. The settled levels are held steady from before start through the end of the window. Transient bursts end well inside the window, so every edge reaches its counter before the enable drops.

// File: rtl/osc_race_pkg.sv
package osc_race_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2,
    ST_DONE = 2'd3
  } rd_state_e;

  typedef enum logic {
    MODE_RING  = 1'b0,
    MODE_TRANS = 1'b1
  } osc_mode_e;
endpackage

// File: rtl/osc_lvl_sync.sv
module osc_lvl_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o
);
  logic [SYNC_N-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-2:0], lvl_i};
  end

  assign lvl_o = sync_q[SYNC_N-1];
endmodule

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic rise_o
);
  logic lvl_s, prev_q;

  osc_lvl_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (osc_i),
    .lvl_o (lvl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_s;
  end

  assign rise_o = lvl_s & ~prev_q;
endmodule

// File: rtl/osc_cell_counter.sv
module osc_cell_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;

  // R3: saturation, never wraps
  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clr_i) |=> full_o)
    else $error("counter wrapped");

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0))
    else $error("counter not cleared");
endmodule

// File: rtl/osc_race_ctrl.sv
module osc_race_ctrl
  import osc_race_pkg::*;
#(
  parameter int WIN_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  input  logic any_full_i,
  output logic clr_o,
  output logic run_o,
  output logic hold_o,
  output logic done_o,
  output logic trans_o
);
  localparam int TMR_W = $clog2(WIN_CYC + 1);
  localparam logic [TMR_W-1:0] WIN_LAST = TMR_W'(WIN_CYC - 1);

  rd_state_e        st_q, st_d;
  logic [TMR_W-1:0] tmr_q;
  logic             trans_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RUN;
      ST_RUN: begin
        if (!trans_q && any_full_i)        st_d = ST_HOLD;
        if (trans_q && (tmr_q == WIN_LAST)) st_d = ST_HOLD;
      end
      ST_HOLD: st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      trans_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        tmr_q <= '0;
        if (start_i) trans_q <= (mode_i == MODE_TRANS);
      end else if (st_q == ST_RUN && trans_q) begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign clr_o   = (st_q == ST_IDLE) && start_i;
  assign run_o   = (st_q == ST_RUN);
  assign hold_o  = (st_q == ST_HOLD);
  assign done_o  = (st_q == ST_DONE);
  assign trans_o = trans_q;

  p_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && trans_o) |-> (tmr_q < TMR_W'(WIN_CYC)))
    else $error("window overrun");

  p_ring_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !trans_o && any_full_i) |=> !run_o)
    else $error("race did not end on full");

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> run_o)
    else $error("start not accepted");
endmodule

// File: rtl/osc_race_readout.sv
module osc_race_readout
  import osc_race_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WIN_CYC   = 1024,
  parameter int SEL_FIRST = 9,
  parameter int SEL_N     = 2,
  parameter int SYNC_N    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             osc_a_i,
  input  logic             osc_b_i,
  input  logic             clps_a_i,
  input  logic             clps_b_i,
  output logic             osc_en_o,
  output logic             done_o,
  output logic             sign_o,
  output logic             tie_o,
  output logic [SEL_N-1:0] loser_bits_o,
  output logic [CNT_W:0]   diff_o,
  output logic             clps_a_o,
  output logic             clps_b_o,
  output logic             mix_o
);
  localparam int N_CELL  = 2;
  localparam int SEL_LSB = CNT_W - SEL_FIRST - (SEL_N - 1);

  initial begin
    if (SEL_FIRST < 1 || SEL_LSB < 0) $error("bad selected bit range");
  end

  logic [N_CELL-1:0]  osc_lvl, clps_lvl, clps_s, rise, inc, full;
  logic [CNT_W-1:0]   cnt [N_CELL];
  logic               clr, run, hold, trans, any_full;

  assign osc_lvl  = {osc_b_i, osc_a_i};
  assign clps_lvl = {clps_b_i, clps_a_i};
  assign any_full = |full;

  for (genvar g = 0; g < N_CELL; g++) begin : g_cell
    osc_edge_sync #(.SYNC_N(SYNC_N)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .osc_i (osc_lvl[g]),
      .rise_o(rise[g])
    );

    osc_lvl_sync #(.SYNC_N(SYNC_N)) u_clps (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (clps_lvl[g]),
      .lvl_o (clps_s[g])
    );

    // ring race freezes both counters once either fills
    assign inc[g] = rise[g] & run & ~(~trans & any_full);

    osc_cell_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .inc_i (inc[g]),
      .cnt_o (cnt[g]),
      .full_o(full[g])
    );
  end

  osc_race_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .any_full_i(any_full),
    .clr_o     (clr),
    .run_o     (run),
    .hold_o    (hold),
    .done_o    (done_o),
    .trans_o   (trans)
  );

  assign osc_en_o = run;

  // result capture during the hold cycle, counters frozen
  logic             a_gt_b, a_eq_b;
  logic [CNT_W-1:0] loser_cnt;

  assign a_gt_b    = cnt[0] > cnt[1];
  assign a_eq_b    = cnt[0] == cnt[1];
  assign loser_cnt = a_gt_b ? cnt[1] : cnt[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sign_o       <= 1'b0;
      tie_o        <= 1'b0;
      loser_bits_o <= '0;
      diff_o       <= '0;
      clps_a_o     <= 1'b0;
      clps_b_o     <= 1'b0;
      mix_o        <= 1'b0;
    end else if (hold) begin
      sign_o       <= a_gt_b;
      tie_o        <= a_eq_b;
      loser_bits_o <= loser_cnt[SEL_LSB +: SEL_N];
      diff_o       <= {1'b0, cnt[0]} - {1'b0, cnt[1]};
      clps_a_o     <= clps_s[0];
      clps_b_o     <= clps_s[1];
      mix_o        <= clps_s[0] ^ clps_s[1] ^ a_gt_b;
    end
  end

  p_tie_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tie_o |-> !sign_o)
    else $error("tie with sign set");

  p_winner_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trans && sign_o) |-> full[0])
    else $error("ring winner not full");

  p_en_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |=> !osc_en_o)
    else $error("enable low gap too short");

  p_done_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !osc_en_o)
    else $error("enable high at done");
endmodule

// File: tb/tb_osc_race_readout.sv
module tb_osc_race_readout;
  localparam int CLK_P     = 10;
  localparam int CNT_W     = 8;
  localparam int WIN_CYC   = 64;
  localparam int SEL_FIRST = 3;
  localparam int SEL_N     = 2;
  localparam int MAXV      = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic osc_a = 1'b0, osc_b = 1'b0, clps_a = 1'b0, clps_b = 1'b0;
  logic osc_en, done, sign, tie, clps_ao, clps_bo, mix;
  logic [SEL_N-1:0] lbits;
  logic [CNT_W:0]   diff;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  osc_race_readout #(
    .CNT_W(CNT_W), .WIN_CYC(WIN_CYC), .SEL_FIRST(SEL_FIRST), .SEL_N(SEL_N), .SYNC_N(2)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .osc_a_i(osc_a), .osc_b_i(osc_b), .clps_a_i(clps_a), .clps_b_i(clps_b),
    .osc_en_o(osc_en), .done_o(done), .sign_o(sign), .tie_o(tie),
    .loser_bits_o(lbits), .diff_o(diff), .clps_a_o(clps_ao), .clps_b_o(clps_bo),
    .mix_o(mix)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // trans=0: ring cells with periods pa/pb; trans=1: bursts of na/nb rises, period 4
  task automatic run_eval(input bit trans, input int pa, input int pb,
                          input int na, input int nb, input bit ca, input bit cb);
    int c, en_cyc, ea, eb, loser, exp_bits, dmask;
    bit es, et;
    c = 0; en_cyc = 0;
    clps_a = ca; clps_b = cb;
    mode = trans;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int it = 0; it < 4000 && !done; it++) begin
      if (osc_en) begin
        if (trans) begin
          osc_a = (c < na*4) && ((c % 4) < 2);
          osc_b = (c < nb*4) && ((c % 4) < 2);
        end else begin
          osc_a = (c % pa) < (pa/2);
          osc_b = (c % pb) < (pb/2);
        end
        c++; en_cyc++;
      end else begin
        osc_a = 1'b0; osc_b = 1'b0;
      end
      start = (trans && c == 10); // R2: start during run must be ignored
      @(negedge clk);
    end
    start = 1'b0;
    if (trans) begin
      ea = na; eb = nb;
    end else if (pa == pb) begin
      ea = MAXV; eb = MAXV;
    end else if (pa < pb) begin
      ea = MAXV; eb = ((MAXV-1)*pa)/pb + 1;
    end else begin
      eb = MAXV; ea = ((MAXV-1)*pb)/pa + 1;
    end
    es = ea > eb;
    et = ea == eb;
    loser = es ? eb : ea;
    exp_bits = (loser >> (CNT_W - SEL_FIRST - (SEL_N-1))) & ((1 << SEL_N) - 1);
    dmask = (1 << (CNT_W+1)) - 1;
    check("R10 done seen", done, 1);
    check("R10 enable low at done", osc_en, 0);
    check(trans ? "R7 sign" : "R4 sign", sign, es);
    check(trans ? "R7 tie" : "R4 tie", tie, et);
    check("R5 loser bits", lbits, exp_bits);
    check("R8 diff", diff, (ea - eb) & dmask);
    if (trans) begin
      check("R6 window length", en_cyc, WIN_CYC);
      check("R9 collapse a", clps_ao, ca);
      check("R9 collapse b", clps_bo, cb);
      check("R9 mix", mix, ca ^ cb ^ es);
    end
    @(negedge clk);
    check("R10 done single cycle", done, 0);
    check("R10 results hold", diff, (ea - eb) & dmask);
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    summary();
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 en", osc_en, 0);
    check("R1 done", done, 0);
    check("R1 sign", sign, 0);
    check("R1 tie", tie, 0);
    check("R1 diff", diff, 0);
    check("R1 bits", lbits, 0);
    check("R1 mix", mix, 0);
    check("R1 clps", {clps_ao, clps_bo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 no start keeps idle", osc_en, 0);

    // R4/R5/R3 ring races
    for (int pa = 3; pa <= 6; pa++)
      for (int pb = 3; pb <= 6; pb++)
        run_eval(1'b0, pa, pb, 0, 0, 1'b0, 1'b0);

    // R6..R9 transient windows
    for (int na = 0; na <= 5; na++)
      for (int nb = 0; nb <= 5; nb++)
        run_eval(1'b1, 0, 0, na, nb, bit'((na + nb) % 2), bit'(na % 2));

    // R10 enable gap with start held high
    start = 1'b1; mode = 1'b1;
    gap = 0;
    for (int it = 0; it < 200 && !done; it++) @(negedge clk);
    for (int it = 0; it < 10 && !osc_en; it++) begin
      gap++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R10 enable gap >= 2", gap >= 2, 1);
    check("R2 restart raises enable", osc_en, 1);
    for (int it = 0; it < 200 && !done; it++) @(negedge clk);
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end
endmodule